// File: doc/BRIEF.md
# PCIe Root-Port Reset and Power Sequencer

This block brings a PCIe root-port link up from power-on in a fixed order. A single-cycle start pulse begins the run. Both PERST# resets go low, board-level first, and slot power is switched on. The resets stay low for a programmable number of cycles, which equals 100 ms at the default clock. Then the controller reset is released, followed by the board reset. After that the auxiliary clock is enabled and the PHY hold-reset is asserted, and only then is the power-up reset released.

At that point the block hands over to an external PHY-programming sub-sequencer through a start pulse and a done input. When the sub-sequencer reports completion, the block gates the auxiliary clock off, clears the PHY hold-reset and turns the clock back on. It then writes the root-complex device type and, as its final step, enables link training. If the sub-sequencer does not answer within a timeout, the run stops with a fault flag. A shutdown request reasserts both PERST# outputs, board first, so that a later boot starts from a clean reset state.

Top module: `pcie_rst_seq`

## Requirements
- R1: After reset, every output is low: slot power, both PERST# (active low, so asserted), PHY hold-reset, power-up reset (asserted), aux clock enable, training enable, phy_start, done and fault, and the device type is 0.
- R2: On start_i while idle, board_perst_no falls at the first clock edge and ctrl_perst_no falls one cycle later. On release, ctrl_perst_no rises first and board_perst_no rises on the next cycle.
- R3: slot_pwr_en_o rises one cycle after ctrl_perst_no falls. ctrl_perst_no then rises exactly PERST_CYC = CLK_HZ/1000*PERST_MS cycles after slot_pwr_en_o rose.
- R4: The following happens on successive cycles after board PERST# release: aux_clk_en_o rises, then phy_hold_rst_o rises, then pwr_up_rst_no rises together with a one-cycle phy_start_o pulse.
- R5: phy_done_i is sampled in every cycle from the phy_start_o cycle onward. The edge that samples it high clears aux_clk_en_o. The next edge clears phy_hold_rst_o, and the edge after that sets aux_clk_en_o again.
- R6: One cycle after the aux clock is re-enabled, dev_type_o becomes DEV_TYPE_RC (default 4, root complex). One cycle later ltssm_en_o becomes 1 and done_o rises in the same cycle. This is the last step of the run.
- R7: done_o stays high until the next accepted start or a shutdown. A start_i pulse during a run has no effect on any output.
- R8: If phy_done_i is not seen within PHY_TMO cycles, counted from the phy_start_o cycle, fault_o rises and the run stops, leaving ltssm_en_o low and done_o low. An accepted start clears fault_o.
- R9: shutdown_i takes priority over start_i in every state. The next edge drives board_perst_no low, ltssm_en_o low and done_o low, and the edge after that drives ctrl_perst_no low. Slot power is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only while idle |
| shutdown_i | input | 1 | Request to take the link back down |
| phy_done_i | input | 1 | Completion from the PHY-programming sub-sequencer |
| slot_pwr_en_o | output | 1 | Slot power enable |
| board_perst_no | output | 1 | Board-level PERST#, active low |
| ctrl_perst_no | output | 1 | Controller PERST, active low |
| phy_hold_rst_o | output | 1 | Holds the PHY and link state machine in reset |
| pwr_up_rst_no | output | 1 | Controller power-up reset, active low |
| aux_clk_en_o | output | 1 | Auxiliary clock enable |
| dev_type_o | output | DEV_TYPE_W | Device-type register value |
| ltssm_en_o | output | 1 | Link training enable |
| phy_start_o | output | 1 | One-cycle start to the PHY sub-sequencer |
| done_o | output | 1 | Sequence completed |
| fault_o | output | 1 | PHY sub-sequencer timed out |

## Verification
The bench builds the block with CLK_HZ = 1000 and PERST_MS = 20, which gives a PERST hold of 20 cycles instead of 12.5 million. This makes complete bring-ups, a restart after shutdown and a restart after fault affordable. PHY_TMO is set to 16, so the timeout path completes in a few dozen cycles. The bench also exercises a sub-sequencer that answers in the same cycle as the start pulse and one that answers five cycles later. The short counts leave the ordering and edge-to-edge spacing identical to the default build.

// File: rtl/pcie_rst_seq_pkg.sv
`timescale 1ns/1ps
package pcie_rst_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_A_CTL, ST_PWR, ST_WAIT, ST_R_BRD, ST_AUX1, ST_HOLD,
    ST_PU, ST_PHY, ST_HCLR, ST_AUX2, ST_DTYPE, ST_LINK, ST_SD_CTL
  } seq_st_e;

  typedef struct packed {
    logic pwr;
    logic brd_n;
    logic ctl_n;
    logic hold;
    logic pu_n;
    logic aux;
    logic ltssm;
  } seq_pins_t;

endpackage

// File: rtl/pcie_rst_seq_timer.sv
`timescale 1ns/1ps
module pcie_rst_seq_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pcie_rst_seq_fsm.sv
`timescale 1ns/1ps
module pcie_rst_seq_fsm
  import pcie_rst_seq_pkg::*;
#(
  parameter int unsigned TW        = 8,
  parameter int unsigned PERST_CYC = 20,
  parameter int unsigned PHY_TMO   = 16,
  parameter int unsigned DTW       = 4,
  parameter int unsigned DT_RC     = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           shutdown_i,
  input  logic           phy_done_i,
  input  logic           tmr_zero_i,
  output logic           tmr_load_o,
  output logic [TW-1:0]  tmr_val_o,
  output logic           tmr_dec_o,
  output seq_pins_t      pins_o,
  output logic [DTW-1:0] dev_type_o,
  output logic           phy_start_o,
  output logic           done_o,
  output logic           fault_o
);

  localparam logic [TW-1:0]  PERST_LD = TW'(PERST_CYC - 1);
  localparam logic [TW-1:0]  PHY_LD   = TW'(PHY_TMO - 1);
  localparam logic [TW-1:0]  PERST_SAT = TW'(PERST_CYC);
  localparam logic [DTW-1:0] RC_VAL   = DTW'(DT_RC);

  seq_st_e        st_q;
  seq_pins_t      pins_q;
  logic [DTW-1:0] dev_type_q;
  logic           phy_start_q, done_q, fault_q;

  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = PERST_LD;
    tmr_dec_o  = 1'b0;
    unique case (st_q)
      ST_PWR:        tmr_load_o = 1'b1;
      ST_PU:   begin tmr_load_o = 1'b1; tmr_val_o = PHY_LD; end
      ST_WAIT,
      ST_PHY:        tmr_dec_o  = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      pins_q      <= '0;
      dev_type_q  <= '0;
      phy_start_q <= 1'b0;
      done_q      <= 1'b0;
      fault_q     <= 1'b0;
    end else begin
      phy_start_q <= 1'b0;
      if (shutdown_i && st_q != ST_SD_CTL) begin
        pins_q.brd_n <= 1'b0;
        pins_q.ltssm <= 1'b0;
        done_q       <= 1'b0;
        st_q         <= ST_SD_CTL;
      end else begin
        unique case (st_q)
          ST_IDLE: if (start_i) begin
            pins_q.brd_n <= 1'b0;
            pins_q.hold  <= 1'b0;
            pins_q.pu_n  <= 1'b0;
            pins_q.aux   <= 1'b0;
            pins_q.ltssm <= 1'b0;
            dev_type_q   <= '0;
            done_q       <= 1'b0;
            fault_q      <= 1'b0;
            st_q         <= ST_A_CTL;
          end
          ST_A_CTL: begin pins_q.ctl_n <= 1'b0; st_q <= ST_PWR; end
          ST_PWR:   begin pins_q.pwr   <= 1'b1; st_q <= ST_WAIT; end
          ST_WAIT: if (tmr_zero_i) begin
            pins_q.ctl_n <= 1'b1;
            st_q         <= ST_R_BRD;
          end
          ST_R_BRD: begin pins_q.brd_n <= 1'b1; st_q <= ST_AUX1; end
          ST_AUX1:  begin pins_q.aux   <= 1'b1; st_q <= ST_HOLD; end
          ST_HOLD:  begin pins_q.hold  <= 1'b1; st_q <= ST_PU;   end
          ST_PU: begin
            pins_q.pu_n <= 1'b1;
            phy_start_q <= 1'b1;
            st_q        <= ST_PHY;
          end
          ST_PHY: begin
            if (phy_done_i) begin
              pins_q.aux <= 1'b0;
              st_q       <= ST_HCLR;
            end else if (tmr_zero_i) begin
              fault_q <= 1'b1;
              st_q    <= ST_IDLE;
            end
          end
          ST_HCLR:  begin pins_q.hold <= 1'b0; st_q <= ST_AUX2;  end
          ST_AUX2:  begin pins_q.aux  <= 1'b1; st_q <= ST_DTYPE; end
          ST_DTYPE: begin dev_type_q  <= RC_VAL; st_q <= ST_LINK; end
          ST_LINK: begin
            pins_q.ltssm <= 1'b1;
            done_q       <= 1'b1;
            st_q         <= ST_IDLE;
          end
          ST_SD_CTL: begin pins_q.ctl_n <= 1'b0; st_q <= ST_IDLE; end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign pins_o      = pins_q;
  assign dev_type_o  = dev_type_q;
  assign phy_start_o = phy_start_q;
  assign done_o      = done_q;
  assign fault_o     = fault_q;

  // cycles with power on while controller PERST held, saturating
  logic [TW-1:0] pw_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           pw_cnt_q <= '0;
    else if (!pins_q.pwr || pins_q.ctl_n)  pw_cnt_q <= '0;
    else if (pw_cnt_q != PERST_SAT)        pw_cnt_q <= pw_cnt_q + 1'b1;
  end

  p_perst_rel_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pins_q.brd_n) |-> pins_q.ctl_n);

  p_perst_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pins_q.ctl_n) |-> (pw_cnt_q == PERST_SAT));

  p_hold_over_pu_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pins_q.pu_n) |-> (pins_q.hold && pins_q.aux));

  p_aux_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pins_q.hold) |-> !pins_q.aux);

  p_rc_before_link_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pins_q.ltssm) |-> ($past(dev_type_q) == RC_VAL));

  p_done_fault_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && fault_q));

  p_perst_asrt_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pins_q.ctl_n) |-> !pins_q.brd_n);

endmodule

// File: rtl/pcie_rst_seq.sv
`timescale 1ns/1ps
module pcie_rst_seq
  import pcie_rst_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned PERST_MS    = 100,
  parameter int unsigned PHY_TMO     = 4096,
  parameter int unsigned DEV_TYPE_W  = 4,
  parameter int unsigned DEV_TYPE_RC = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  shutdown_i,
  input  logic                  phy_done_i,
  output logic                  slot_pwr_en_o,
  output logic                  board_perst_no,
  output logic                  ctrl_perst_no,
  output logic                  phy_hold_rst_o,
  output logic                  pwr_up_rst_no,
  output logic                  aux_clk_en_o,
  output logic [DEV_TYPE_W-1:0] dev_type_o,
  output logic                  ltssm_en_o,
  output logic                  phy_start_o,
  output logic                  done_o,
  output logic                  fault_o
);

  localparam int unsigned PERST_CYC = CLK_HZ / 1000 * PERST_MS;
  localparam int unsigned MAX_CYC   = (PERST_CYC > PHY_TMO) ? PERST_CYC : PHY_TMO;
  localparam int unsigned TW        = $clog2(MAX_CYC + 1);

  logic          tmr_load, tmr_dec, tmr_zero;
  logic [TW-1:0] tmr_val;
  seq_pins_t     pins;

  pcie_rst_seq_timer #(.TW(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .dec_i      (tmr_dec),
    .zero_o     (tmr_zero)
  );

  pcie_rst_seq_fsm #(
    .TW        (TW),
    .PERST_CYC (PERST_CYC),
    .PHY_TMO   (PHY_TMO),
    .DTW       (DEV_TYPE_W),
    .DT_RC     (DEV_TYPE_RC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .shutdown_i  (shutdown_i),
    .phy_done_i  (phy_done_i),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .tmr_dec_o   (tmr_dec),
    .pins_o      (pins),
    .dev_type_o  (dev_type_o),
    .phy_start_o (phy_start_o),
    .done_o      (done_o),
    .fault_o     (fault_o)
  );

  assign slot_pwr_en_o  = pins.pwr;
  assign board_perst_no = pins.brd_n;
  assign ctrl_perst_no  = pins.ctl_n;
  assign phy_hold_rst_o = pins.hold;
  assign pwr_up_rst_no  = pins.pu_n;
  assign aux_clk_en_o   = pins.aux;
  assign ltssm_en_o     = pins.ltssm;

endmodule

// File: tb/pcie_rst_seq_test.sv
`timescale 1ns/1ps
module pcie_rst_seq_test;

  localparam int N   = 20;  // PERST hold cycles for CLK_HZ=1000, PERST_MS=20
  localparam int TMO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, shutdown = 1'b0, phy_done = 1'b0;
  logic o_pwr, o_brd, o_ctl, o_hold, o_pu, o_aux, o_lt, o_ps, o_done, o_fault;
  logic [3:0] o_dev;

  int vectors = 0, miscmp = 0;
  int phy_delay = 5;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pcie_rst_seq #(.CLK_HZ(1000), .PERST_MS(20), .PHY_TMO(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .shutdown_i(shutdown),
    .phy_done_i(phy_done), .slot_pwr_en_o(o_pwr), .board_perst_no(o_brd),
    .ctrl_perst_no(o_ctl), .phy_hold_rst_o(o_hold), .pwr_up_rst_no(o_pu),
    .aux_clk_en_o(o_aux), .dev_type_o(o_dev), .ltssm_en_o(o_lt),
    .phy_start_o(o_ps), .done_o(o_done), .fault_o(o_fault)
  );

  task automatic cmp(string req, string nm, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  // behavioural reference
  int step = 0, w = 0;
  bit m_pwr, m_brd, m_ctl, m_hold, m_pu, m_aux, m_lt, m_ps, m_done, m_fault;
  int m_dev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step = 0; w = 0; m_dev = 0;
      {m_pwr, m_brd, m_ctl, m_hold, m_pu, m_aux, m_lt, m_ps, m_done, m_fault} = '0;
    end else begin
      m_ps = 0;
      if (shutdown && step != 13) begin
        m_brd = 0; m_lt = 0; m_done = 0; step = 13;
      end else begin
        case (step)
          0: if (start) begin
               m_brd = 0; m_hold = 0; m_pu = 0; m_aux = 0; m_lt = 0;
               m_dev = 0; m_done = 0; m_fault = 0; step = 1;
             end
          1: begin m_ctl = 0; step = 2; end
          2: begin m_pwr = 1; w = 0; step = 3; end
          3: begin w++; if (w == N) begin m_ctl = 1; step = 4; end end
          4: begin m_brd = 1; step = 5; end
          5: begin m_aux = 1; step = 6; end
          6: begin m_hold = 1; step = 7; end
          7: begin m_pu = 1; m_ps = 1; w = 0; step = 8; end
          8: if (phy_done) begin m_aux = 0; step = 9; end
             else begin w++; if (w == TMO) begin m_fault = 1; step = 0; end end
          9:  begin m_hold = 0; step = 10; end
          10: begin m_aux = 1; step = 11; end
          11: begin m_dev = 4; step = 12; end
          12: begin m_lt = 1; m_done = 1; step = 0; end
          13: begin m_ctl = 0; step = 0; end
          default: step = 0;
        endcase
      end
    end
  end

  // every-cycle comparison
  initial forever begin
    @(negedge clk);
    if (rst_n && !finished) begin
      cmp("R3", "slot_pwr_en", o_pwr, m_pwr);
      cmp("R2", "board_perst_n", o_brd, m_brd);
      cmp("R2", "ctrl_perst_n", o_ctl, m_ctl);
      cmp("R4", "phy_hold_rst", o_hold, m_hold);
      cmp("R4", "pwr_up_rst_n", o_pu, m_pu);
      cmp("R5", "aux_clk_en", o_aux, m_aux);
      cmp("R6", "dev_type", o_dev, m_dev);
      cmp("R6", "ltssm_en", o_lt, m_lt);
      cmp("R4", "phy_start", o_ps, m_ps);
      cmp("R7", "done", o_done, m_done);
      cmp("R8", "fault", o_fault, m_fault);
    end
  end

  // PHY sub-sequencer responder
  initial begin
    int pend = 0;
    forever begin
      @(negedge clk);
      phy_done = 1'b0;
      if (pend > 0) begin pend--; if (pend == 0) phy_done = 1'b1; end
      if (o_ps && phy_delay >= 0) begin
        if (phy_delay == 0) phy_done = 1'b1;
        else pend = phy_delay;
      end
    end
  end

  // PERST hold measurement
  int hold_len = 0, last_len = -1;
  initial forever begin
    @(negedge clk);
    if (o_pwr && !o_ctl) hold_len++;
    else begin
      if (hold_len > 0 && o_ctl) last_len = hold_len;
      hold_len = 0;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_shutdown();
    @(negedge clk); shutdown = 1'b1; @(negedge clk); shutdown = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(2);
    // R1 reset state
    cmp("R1", "rst pwr", o_pwr, 0);
    cmp("R1", "rst board_perst_n", o_brd, 0);
    cmp("R1", "rst ctrl_perst_n", o_ctl, 0);
    cmp("R1", "rst hold", o_hold, 0);
    cmp("R1", "rst pu_n", o_pu, 0);
    cmp("R1", "rst aux", o_aux, 0);
    cmp("R1", "rst dev_type", o_dev, 0);
    cmp("R1", "rst ltssm", o_lt, 0);
    cmp("R1", "rst done/fault/ps", {o_done, o_fault, o_ps}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // full run, PHY answers after 5 cycles; extra start mid-run (R7)
    phy_delay = 5;
    pulse_start();
    idle(8);
    pulse_start();
    idle(50);
    cmp("R3", "perst hold cycles", last_len, N);
    cmp("R6", "ltssm after run", o_lt, 1);
    cmp("R6", "dev_type rc", o_dev, 4);
    idle(10);
    cmp("R7", "done held", o_done, 1);

    // shutdown
    pulse_shutdown();
    idle(4);
    cmp("R9", "shutdown board_perst_n", o_brd, 0);
    cmp("R9", "shutdown ctrl_perst_n", o_ctl, 0);
    cmp("R9", "shutdown ltssm/done", {o_lt, o_done}, 0);
    cmp("R9", "shutdown pwr kept", o_pwr, 1);

    // PHY never answers
    phy_delay = -1;
    pulse_start();
    idle(70);
    cmp("R8", "timeout fault", o_fault, 1);
    cmp("R8", "timeout ltssm", o_lt, 0);
    cmp("R8", "timeout done", o_done, 0);

    // PHY answers in the start cycle
    phy_delay = 0;
    pulse_start();
    idle(60);
    cmp("R8", "fault cleared", o_fault, 0);
    cmp("R6", "fast phy done", o_done, 1);

    // start and shutdown together mid-run
    phy_delay = 3;
    pulse_start();
    idle(5);
    @(negedge clk); start = 1'b1; shutdown = 1'b1;
    @(negedge clk); start = 1'b0; shutdown = 1'b0;
    idle(5);
    cmp("R9", "priority board_perst_n", o_brd, 0);
    cmp("R9", "priority ctrl_perst_n", o_ctl, 0);
    cmp("R9", "priority ltssm", o_lt, 0);
    idle(30);
    cmp("R9", "stays down", {o_brd, o_ctl}, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      miscmp++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

endmodule